// File: doc/BRIEF.md
# Multi-Operand Modulo (2^N-1) Adder

This block adds a set of unsigned N-bit operands and returns their total reduced modulo 2^N-1. The number of operands is 2K+3, where K is a build parameter. This count matches the number of terms a residue-to-binary converter must combine, which is the block's main use. The adder is equally suited to any datapath that needs a wide multi-operand sum in a one's-complement style ring.

A chain of 2K+1 carry-save stages reduces the operands. Each stage rotates its top carry bit back into bit 0, so every stage keeps the running total congruent modulo 2^N-1. A final carry-propagate adder folds its carry-out back in as a single increment. It then maps the all-ones pattern to zero. The result is registered, and a new set of operands may be applied every cycle.

Top module: `emac_top`

## Requirements
- R1: One clock edge after the operands are presented, `res_o` equals the sum of all 2K+3 operands, reduced modulo 2^N-1.
- R2: `res_o` is always in the range 0 to 2^N-2. The all-ones pattern never appears on the output, and a zero residue is shown as all zeros.
- R3: The end-around increment of the final adder never produces a further carry-out.
- R4: An operand equal to all ones contributes the same as an operand of zero.
- R5: Operand j occupies bits [j*N +: N] of `ops_i`, for j from 0 to 2K+2. Every slot contributes to the sum with weight one.
- R6: While `rst_n` is low, `res_o` is zero.
- R7: The same RTL serves any K ≥ 0. The bench covers K=0, K=1 and K=2, which take 3, 5 and 7 operands.
- R8: When the operands are held constant, `res_o` holds constant from the second edge onwards.
- R9: An all-zero operand set yields zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| ops_i | input | (2K+3)*N | Packed operands; operand j at bits [j*N +: N] |
| res_o | output | N | Registered sum modulo 2^N-1 |

## Verification
Every result appears exactly one rising edge after its operands are presented. The bench drives a new operand set on each falling edge. It compares `res_o` on the following falling edge, after exactly one capture edge, so each comparison pairs with the vector driven just before it. The K=0 instance is swept over every combination of three 4-bit operands. The K=1 and K=2 instances see the same vectors extended with random operands. Directed sets then target all-ones operands, per-slot weighting, maximum totals and reset.

// File: rtl/emac_pkg.sv
package emac_pkg;
  // operand count for a given K
  function automatic int op_count(input int k);
    return 2 * k + 3;
  endfunction

  // carry-save stages needed to reduce op_count(k) words to two
  function automatic int stage_count(input int k);
    return 2 * k + 1;
  endfunction
endpackage

// File: rtl/emac_csa_stage.sv
module emac_csa_stage #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] carry_o
);
  // per-bit majority; its weight-2^N bit wraps to weight 1 mod 2^N-1
  function automatic logic [N-1:0] rot_carry(input logic [N-1:0] a,
                                             input logic [N-1:0] b,
                                             input logic [N-1:0] d);
    logic [N-1:0] maj;
    maj = (a & b) | (a & d) | (b & d);
    return {maj[N-2:0], maj[N-1]};
  endfunction

  always_comb begin
    sum_o   = a_i ^ b_i ^ d_i;
    carry_o = rot_carry(a_i, b_i, d_i);
  end
endmodule

// File: rtl/emac_csa_chain.sv
module emac_csa_chain #(
  parameter int N    = 8,
  parameter int NOPS = 5
) (
  input  logic [NOPS*N-1:0] ops_i,
  output logic [N-1:0]      sum_o,
  output logic [N-1:0]      carry_o
);
  localparam int NSTG = NOPS - 2;

  logic [N-1:0] s_w [NSTG];
  logic [N-1:0] c_w [NSTG];

  for (genvar j = 0; j < NSTG; j++) begin : g_stage
    if (j == 0) begin : g_first
      emac_csa_stage #(.N(N)) stage_i (
        .a_i    (ops_i[0*N +: N]),
        .b_i    (ops_i[1*N +: N]),
        .d_i    (ops_i[2*N +: N]),
        .sum_o  (s_w[j]),
        .carry_o(c_w[j])
      );
    end else begin : g_next
      emac_csa_stage #(.N(N)) stage_i (
        .a_i    (s_w[j-1]),
        .b_i    (c_w[j-1]),
        .d_i    (ops_i[(j+2)*N +: N]),
        .sum_o  (s_w[j]),
        .carry_o(c_w[j])
      );
    end
  end

  assign sum_o   = s_w[NSTG-1];
  assign carry_o = c_w[NSTG-1];
endmodule

// File: rtl/emac_final_add.sv
module emac_final_add #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] res_o,
  output logic         wrap_ovf_o
);
  // first pass: plain add with carry-out
  function automatic logic [N:0] add_plain(input logic [N-1:0] a,
                                           input logic [N-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // second pass: fold carry-out back in as an increment
  function automatic logic [N:0] fold(input logic [N:0] s);
    return {1'b0, s[N-1:0]} + {{N{1'b0}}, s[N]};
  endfunction

  logic [N:0]   pass1;
  logic [N:0]   pass2;
  logic [N-1:0] folded;

  always_comb begin
    pass1      = add_plain(a_i, b_i);
    pass2      = fold(pass1);
    folded     = pass2[N-1:0];
    wrap_ovf_o = pass2[N];
    res_o      = (&folded) ? '0 : folded;
  end
endmodule

// File: rtl/emac_top.sv
module emac_top #(
  parameter int K = 1,
  parameter int N = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [emac_pkg::op_count(K)*N-1:0]   ops_i,
  output logic [N-1:0]                         res_o
);
  localparam int NOPS = emac_pkg::op_count(K);
  localparam int W    = NOPS * N;

  logic [N-1:0] tree_sum;
  logic [N-1:0] tree_carry;
  logic [N-1:0] res_d;
  logic         wrap_ovf;
  logic [N-1:0] res_q;
  logic         primed_q;
  logic         ops_zero;

  emac_csa_chain #(.N(N), .NOPS(NOPS)) chain_i (
    .ops_i  (ops_i),
    .sum_o  (tree_sum),
    .carry_o(tree_carry)
  );

  emac_final_add #(.N(N)) final_i (
    .a_i       (tree_sum),
    .b_i       (tree_carry),
    .res_o     (res_d),
    .wrap_ovf_o(wrap_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      res_q    <= res_d;
      primed_q <= 1'b1;
    end
  end

  assign res_o    = res_q;
  assign ops_zero = (ops_i == '0);

  assert_no_allones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_q != {N{1'b1}});

  assert_no_second_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_ovf);

  assert_zero_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ops_zero |=> (res_q == '0));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $stable(ops_i)) |=> $stable(res_q));

  assert_reset_R6: assert property (@(posedge clk)
    !rst_n |=> (res_q == '0));

  initial begin
    assert_width_R7: assert (W == (2 * K + 3) * N && N >= 2);
  end
endmodule

// File: tb/emac_top_tb_top.sv
module emac_top_tb_top;
  localparam int N  = 4;
  localparam int MD = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic [N-1:0] op [7];
  logic [3*N-1:0] ops0;
  logic [5*N-1:0] ops1;
  logic [7*N-1:0] ops2;
  logic [N-1:0] r0, r1, r2;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  emac_top #(.K(0), .N(N)) dut_i    (.clk(clk), .rst_n(rst_n), .ops_i(ops0), .res_o(r0));
  emac_top #(.K(1), .N(N)) dut_k1_i (.clk(clk), .rst_n(rst_n), .ops_i(ops1), .res_o(r1));
  emac_top #(.K(2), .N(N)) dut_k2_i (.clk(clk), .rst_n(rst_n), .ops_i(ops2), .res_o(r2));

  function automatic int model(input int cnt);
    int acc = 0;
    for (int j = 0; j < cnt; j++) acc += int'(op[j]);
    return acc % MD;
  endfunction

  task automatic pack();
    for (int j = 0; j < 7; j++) begin
      if (j < 3) ops0[j*N +: N] = op[j];
      if (j < 5) ops1[j*N +: N] = op[j];
      ops2[j*N +: N] = op[j];
    end
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input int exp);
    n_vec++;
    if (int'(act) != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on falling edge, one capture edge, compare on next falling edge
  task automatic apply(input string req);
    int e0, e1, e2;
    pack();
    e0 = model(3); e1 = model(5); e2 = model(7);
    @(posedge clk);
    @(negedge clk);
    check({req, " k0"}, r0, e0);
    check({req, " k1"}, r1, e1);
    check({req, " k2"}, r2, e2);
  endtask

  initial begin
    for (int j = 0; j < 7; j++) op[j] = 4'hF;
    pack();
    repeat (3) @(negedge clk);
    check("R6 reset k0", r0, 0);
    check("R6 reset k1", r1, 0);
    check("R6 reset k2", r2, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R7 exhaustive over K=0 operands, random tails for K=1,2
    for (int v = 0; v < (1 << (3*N)); v++) begin
      op[0] = v[3:0]; op[1] = v[7:4]; op[2] = v[11:8];
      for (int j = 3; j < 7; j++) op[j] = N'($urandom);
      apply("R1 R7 sweep");
    end

    // R4: all-ones operands behave as zero
    for (int j = 0; j < 7; j++) op[j] = 4'hF;
    apply("R4 all-ones");
    for (int j = 0; j < 7; j++) op[j] = (j % 2 == 0) ? 4'hF : 4'h5;
    apply("R4 mixed all-ones");

    // R5: one nonzero slot at a time
    for (int s = 0; s < 7; s++) begin
      for (int j = 0; j < 7; j++) op[j] = (j == s) ? 4'h3 : 4'h0;
      apply("R5 slot weight");
    end

    // R2: maximal totals and exact multiples
    for (int j = 0; j < 7; j++) op[j] = 4'hE;
    apply("R2 max operands");
    op[0] = 4'h7; op[1] = 4'h8; op[2] = 4'h0;
    op[3] = 4'h5; op[4] = 4'hA; op[5] = 4'h1; op[6] = 4'hE;
    apply("R2 multiple of modulus");

    // R9: zero operands
    for (int j = 0; j < 7; j++) op[j] = 4'h0;
    apply("R9 zero");

    // R8: hold operands, output stays
    for (int j = 0; j < 7; j++) op[j] = N'(j * 3 + 1);
    apply("R8 hold a");
    apply("R8 hold b");

    // R6: reset again clears the register
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 re-reset k0", r0, 0);
    check("R6 re-reset k1", r1, 0);
    check("R6 re-reset k2", r2, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule